// File: doc/BRIEF.md
# UART Task/Event Register Controller

This block is the software-facing control layer of a small serial port. Software drives it through 32-bit word-aligned reads and writes on a simple strobe bus. Some registers are tasks: writing the value 1 starts or stops the transmitter or receiver. Other registers are events: hardware sets them and software clears them. The block holds the interrupt mask and the error-source register. It also keeps plain storage for the baud and pin-select settings, which are consumed elsewhere.

The transmit side offers one byte at a time to an external serializer. The byte is held on `tx_byte` with `tx_valid` high until the serializer answers with `tx_done`. The receive side gets three signals from an external deserializer: a per-byte strobe, a line-break indication, and a `rx_on` level that tells it whether the receiver is running.

Nothing is reachable until software writes the value 4 to the enable register. Writing 0 there shuts the port down and records a receiver-timeout event. A single registered interrupt line combines the four events with their mask bits.

Top module: `uart_evctl`

## Requirements
- R1: After reset, the four pin-select registers (offsets 0xD0, 0xD4, 0xD8, 0xDC) read 0xFFFFFFFF and the baud register (0xE4) reads 0x04000000 once the block is enabled. Mask, error-source and event registers read 0. `irq`, `tx_valid` and `rx_on` are low.
- R2: Writing 4 to the enable register (0xC4) enables the block, and it then reads back 4. Writing 0 disables it, clears transmitter-started and receiver-started, and sets the receiver-timeout event. Any other value has no effect.
- R3: While disabled, `bus_rdata` is 0 for every read and every write is ignored, except a write to the enable register.
- R4: The interrupt mask (bit0 receive-ready, bit1 transmit-ready, bit2 error, bit3 receiver-timeout) is loaded by a write to 0x80. A write to 0x84 ORs bits in, and a write to 0x88 clears the bits written as 1. A read of any of the three offsets returns the mask.
- R5: `irq` is high in the cycle after any event whose mask bit is set is present. It falls one cycle after no such event remains.
- R6: Start-receive (0x00) and start-transmit (0x08) act only when written with exactly 1. `rx_on` shows the receiver-started state.
- R7: Stop-transmit (0x0C) with 1 clears only transmitter-started. Stop-receive (0x04) with 1 clears receiver-started and sets receiver-timeout. Suspend (0x10) with 1 does both.
- R8: A write to transmit-data (0xE0) is accepted only when the transmitter is started and no byte is pending. The accepted byte then appears on `tx_byte` with `tx_valid` high and stays unchanged until `tx_done`. `tx_done` drops `tx_valid` and sets the transmit-ready event (0x44).
- R9: `rx_break` sets error-source bits [1:0] and the error event (0x48). The error-source register (0xC0) clears the bits written as 1.
- R10: The receive-ready event (0x40) is set by `rx_byte_evt` and is cleared by software only by writing 0. Any write to the transmit-ready, error and receiver-timeout events loads them: a nonzero value gives 1, zero gives 0.
- R11: Baud and pin-select registers store whatever is written. Unmapped offsets and task offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| tx_valid | output | 1 | A byte is pending for the serializer |
| tx_byte | output | 8 | Byte to send |
| tx_done | input | 1 | Serializer finished the pending byte |
| rx_on | output | 1 | Receiver-started state |
| rx_byte_evt | input | 1 | Deserializer delivered a byte |
| rx_break | input | 1 | Line break detected |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a second transmit-data write that arrives while a byte is still pending. The transmitter must be started with exactly 1, a first byte accepted, and the serializer held off so that `tx_done` stays low. The bench creates this by keeping `tx_done` idle across a second write and checking that `tx_byte` still carries the first value. Only then does it pulse `tx_done`. The masked-interrupt path is covered the same way. The bench raises an event with its mask bit clear, then opens the mask, then checks the one-cycle delay of `irq` on both the rising and the falling side.

// File: rtl/uart_evctl.sv
module uart_evctl #(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] PSEL_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] BAUD_RST = 32'h0400_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_done,
  output logic              rx_on,
  input  logic              rx_byte_evt,
  input  logic              rx_break,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_START_RX = ADDR_W'(32'h00);
  localparam logic [ADDR_W-1:0] A_STOP_RX  = ADDR_W'(32'h04);
  localparam logic [ADDR_W-1:0] A_START_TX = ADDR_W'(32'h08);
  localparam logic [ADDR_W-1:0] A_STOP_TX  = ADDR_W'(32'h0C);
  localparam logic [ADDR_W-1:0] A_SUSPEND  = ADDR_W'(32'h10);
  localparam logic [ADDR_W-1:0] A_EV_RXRDY = ADDR_W'(32'h40);
  localparam logic [ADDR_W-1:0] A_EV_TXRDY = ADDR_W'(32'h44);
  localparam logic [ADDR_W-1:0] A_EV_ERR   = ADDR_W'(32'h48);
  localparam logic [ADDR_W-1:0] A_EV_RXTO  = ADDR_W'(32'h4C);
  localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(32'h80);
  localparam logic [ADDR_W-1:0] A_MASK_SET = ADDR_W'(32'h84);
  localparam logic [ADDR_W-1:0] A_MASK_CLR = ADDR_W'(32'h88);
  localparam logic [ADDR_W-1:0] A_ERRSRC   = ADDR_W'(32'hC0);
  localparam logic [ADDR_W-1:0] A_ENABLE   = ADDR_W'(32'hC4);
  localparam logic [ADDR_W-1:0] A_PSEL0    = ADDR_W'(32'hD0);
  localparam logic [ADDR_W-1:0] A_PSEL1    = ADDR_W'(32'hD4);
  localparam logic [ADDR_W-1:0] A_PSEL2    = ADDR_W'(32'hD8);
  localparam logic [ADDR_W-1:0] A_PSEL3    = ADDR_W'(32'hDC);
  localparam logic [ADDR_W-1:0] A_TXDATA   = ADDR_W'(32'hE0);
  localparam logic [ADDR_W-1:0] A_BAUD     = ADDR_W'(32'hE4);

  logic        enabled, tx_on, rx_on_q, tx_pend, irq_q;
  logic [7:0]  txd;
  logic [3:0]  ev;
  logic [3:0]  mask;
  logic [3:0]  errsrc;
  logic [31:0] psel [4];
  logic [31:0] baud;
  logic [31:0] rd_val;

  wire wr_ok = bus_wr && (enabled || bus_addr == A_ENABLE);
  wire wv1   = bus_wdata == 32'd1;
  wire wv0   = bus_wdata == 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      tx_on   <= 1'b0;
      rx_on_q <= 1'b0;
      tx_pend <= 1'b0;
      txd     <= '0;
      ev      <= '0;
      mask    <= '0;
      errsrc  <= '0;
      baud    <= BAUD_RST;
      for (int i = 0; i < 4; i++) psel[i] <= PSEL_RST;
    end else begin
      if (wr_ok) begin
        case (bus_addr)
          A_START_RX: if (wv1) rx_on_q <= 1'b1;
          A_STOP_RX:  if (wv1) begin rx_on_q <= 1'b0; ev[3] <= 1'b1; end
          A_START_TX: if (wv1) tx_on <= 1'b1;
          A_STOP_TX:  if (wv1) tx_on <= 1'b0;
          A_SUSPEND:  if (wv1) begin tx_on <= 1'b0; rx_on_q <= 1'b0; ev[3] <= 1'b1; end
          A_EV_RXRDY: if (wv0) ev[0] <= 1'b0;
          A_EV_TXRDY: ev[1] <= !wv0;
          A_EV_ERR:   ev[2] <= !wv0;
          A_EV_RXTO:  ev[3] <= !wv0;
          A_MASK:     mask <= bus_wdata[3:0];
          A_MASK_SET: mask <= mask | bus_wdata[3:0];
          A_MASK_CLR: mask <= mask & ~bus_wdata[3:0];
          A_ERRSRC:   errsrc <= errsrc & ~bus_wdata[3:0];
          A_ENABLE: begin
            if (bus_wdata == 32'd4) enabled <= 1'b1;
            else if (wv0) begin
              enabled <= 1'b0;
              tx_on   <= 1'b0;
              rx_on_q <= 1'b0;
              ev[3]   <= 1'b1;
            end
          end
          A_PSEL0:    psel[0] <= bus_wdata;
          A_PSEL1:    psel[1] <= bus_wdata;
          A_PSEL2:    psel[2] <= bus_wdata;
          A_PSEL3:    psel[3] <= bus_wdata;
          A_BAUD:     baud <= bus_wdata;
          A_TXDATA:   if (tx_on && !tx_pend) begin
                        txd     <= bus_wdata[7:0];
                        tx_pend <= 1'b1;
                      end
          default: ;
        endcase
      end
      if (rx_byte_evt) ev[0] <= 1'b1;
      if (rx_break) begin
        ev[2]  <= 1'b1;
        errsrc <= errsrc | 4'b0011;
      end
      if (tx_done && tx_pend) begin
        ev[1]   <= 1'b1;
        tx_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(ev & mask);

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_EV_RXRDY: rd_val = {31'd0, ev[0]};
      A_EV_TXRDY: rd_val = {31'd0, ev[1]};
      A_EV_ERR:   rd_val = {31'd0, ev[2]};
      A_EV_RXTO:  rd_val = {31'd0, ev[3]};
      A_MASK, A_MASK_SET, A_MASK_CLR: rd_val = {28'd0, mask};
      A_ERRSRC:   rd_val = {28'd0, errsrc};
      A_ENABLE:   rd_val = enabled ? 32'd4 : 32'd0;
      A_PSEL0:    rd_val = psel[0];
      A_PSEL1:    rd_val = psel[1];
      A_PSEL2:    rd_val = psel[2];
      A_PSEL3:    rd_val = psel[3];
      A_TXDATA:   rd_val = {24'd0, txd};
      A_BAUD:     rd_val = baud;
      default:    rd_val = '0;
    endcase
  end

  assign bus_rdata = (bus_rd && enabled) ? rd_val : 32'd0;
  assign tx_valid  = tx_pend;
  assign tx_byte   = txd;
  assign rx_on     = rx_on_q;
  assign irq       = irq_q;

  a_r3_disabled_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> bus_rdata == 32'd0);

  a_r2_disable_sets_rxto: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENABLE && wv0) |=> (!enabled && !tx_on && !rx_on && ev[3]));

  a_r9_break_sets_error: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> (ev[2] && errsrc[1:0] == 2'b11));

  a_r8_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_byte)));

  a_r8_accept_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(bus_wr && bus_addr == A_TXDATA));

  a_r7_stop_tx_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && bus_wr && bus_addr == A_STOP_TX && !rx_break) |=> $stable(rx_on));

  a_r5_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev & mask) == 4'd0) |=> !irq);

endmodule

// File: tb/uart_evctl_tb_top.sv
module uart_evctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, rx_on, irq;
  logic [7:0]  tx_byte;
  logic        tx_done = 1'b0, rx_byte_evt = 1'b0, rx_break = 1'b0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uart_evctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_done(tx_done),
    .rx_on(rx_on), .rx_byte_evt(rx_byte_evt), .rx_break(rx_break), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_rxbyte;
    @(negedge clk); rx_byte_evt = 1'b1; @(negedge clk); rx_byte_evt = 1'b0;
  endtask
  task automatic pulse_break;
    @(negedge clk); rx_break = 1'b1; @(negedge clk); rx_break = 1'b0;
  endtask
  task automatic pulse_done;
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic t_reset_and_enable;
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 0);
    chk("R1 rx_on", {31'd0, rx_on}, 0);
    rdchk("R3 disabled read", 8'hD0, 32'h0);
    wr(8'hC4, 32'd5);
    rdchk("R2 value 5 does not enable", 8'hD0, 32'h0);
    wr(8'hC4, 32'd4);
    rdchk("R2 enable reads 4", 8'hC4, 32'd4);
    rdchk("R1 psel0", 8'hD0, 32'hFFFF_FFFF);
    rdchk("R1 psel3", 8'hDC, 32'hFFFF_FFFF);
    rdchk("R1 baud", 8'hE4, 32'h0400_0000);
    rdchk("R1 mask", 8'h80, 32'h0);
    rdchk("R1 errsrc", 8'hC0, 32'h0);
    rdchk("R1 rxto", 8'h4C, 32'h0);
    wr(8'hC4, 32'd7);
    rdchk("R2 value 7 keeps enabled", 8'hC4, 32'd4);
  endtask

  task automatic t_disabled;
    wr(8'h00, 32'd1);
    wr(8'h08, 32'd1);
    wr(8'hC4, 32'd0);
    #1 chk("R2 disable stops receiver", {31'd0, rx_on}, 0);
    wr(8'h80, 32'hF);
    wr(8'h00, 32'd1);
    #1 chk("R3 start ignored while disabled", {31'd0, rx_on}, 0);
    rdchk("R3 read while disabled", 8'hE4, 32'h0);
    wr(8'hC4, 32'd4);
    rdchk("R3 mask write ignored", 8'h80, 32'h0);
    rdchk("R2 rxto set by disable", 8'h4C, 32'd1);
    wr(8'hE0, 32'h11);
    #1 chk("R2 transmitter stopped by disable", {31'd0, tx_valid}, 0);
    wr(8'h4C, 32'd0);
    rdchk("R10 rxto loaded 0", 8'h4C, 32'd0);
  endtask

  task automatic t_mask;
    wr(8'h80, 32'h5);
    rdchk("R4 mask load", 8'h80, 32'h5);
    wr(8'h84, 32'hA);
    rdchk("R4 set alias", 8'h88, 32'hF);
    wr(8'h88, 32'h3);
    rdchk("R4 clear alias", 8'h84, 32'hC);
    wr(8'h80, 32'h0);
  endtask

  task automatic t_irq;
    pulse_rxbyte;
    @(negedge clk);
    chk("R5 masked event no irq", {31'd0, irq}, 0);
    rdchk("R10 rxrdy set", 8'h40, 32'd1);
    wr(8'h84, 32'h1);
    chk("R5 irq not yet", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R5 irq one cycle later", {31'd0, irq}, 1);
    wr(8'h40, 32'd1);
    rdchk("R10 rxrdy not cleared by 1", 8'h40, 32'd1);
    wr(8'h40, 32'd0);
    chk("R5 irq still high", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R5 irq falls", {31'd0, irq}, 0);
    wr(8'h80, 32'h0);
  endtask

  task automatic t_tasks;
    wr(8'h00, 32'd2);
    #1 chk("R6 start rx with 2", {31'd0, rx_on}, 0);
    wr(8'h00, 32'd1);
    #1 chk("R6 start rx with 1", {31'd0, rx_on}, 1);
    wr(8'h08, 32'd2);
    wr(8'hE0, 32'h22);
    #1 chk("R6 start tx with 2", {31'd0, tx_valid}, 0);
    wr(8'h08, 32'd1);
    wr(8'h0C, 32'd1);
    #1 chk("R7 stop tx keeps rx", {31'd0, rx_on}, 1);
    rdchk("R7 stop tx no rxto", 8'h4C, 32'd0);
    wr(8'hE0, 32'h23);
    #1 chk("R7 stop tx blocks data", {31'd0, tx_valid}, 0);
    wr(8'h04, 32'd1);
    #1 chk("R7 stop rx", {31'd0, rx_on}, 0);
    rdchk("R7 stop rx rxto", 8'h4C, 32'd1);
    wr(8'h4C, 32'd0);
    wr(8'h00, 32'd1);
    wr(8'h08, 32'd1);
    wr(8'h10, 32'd1);
    #1 chk("R7 suspend rx", {31'd0, rx_on}, 0);
    rdchk("R7 suspend rxto", 8'h4C, 32'd1);
    wr(8'hE0, 32'h24);
    #1 chk("R7 suspend tx", {31'd0, tx_valid}, 0);
    wr(8'h4C, 32'd0);
  endtask

  task automatic t_tx;
    wr(8'h08, 32'd1);
    wr(8'hE0, 32'hA5);
    #1 chk("R8 tx_valid", {31'd0, tx_valid}, 1);
    chk("R8 tx_byte", {24'd0, tx_byte}, 32'hA5);
    wr(8'hE0, 32'h3C);
    #1 chk("R8 pending byte kept", {24'd0, tx_byte}, 32'hA5);
    rdchk("R8 txrdy before done", 8'h44, 32'd0);
    pulse_done;
    #1 chk("R8 done clears valid", {31'd0, tx_valid}, 0);
    rdchk("R8 txrdy set", 8'h44, 32'd1);
    wr(8'hE0, 32'h3C);
    #1 chk("R8 next byte", {24'd0, tx_byte}, 32'h3C);
    pulse_done;
    wr(8'h0C, 32'd1);
  endtask

  task automatic t_err;
    pulse_break;
    rdchk("R9 errsrc", 8'hC0, 32'd3);
    rdchk("R9 error event", 8'h48, 32'd1);
    wr(8'hC0, 32'd1);
    rdchk("R9 w1c bit0", 8'hC0, 32'd2);
    wr(8'hC0, 32'd2);
    rdchk("R9 w1c bit1", 8'hC0, 32'd0);
    wr(8'h48, 32'd0);
    rdchk("R10 error loaded 0", 8'h48, 32'd0);
    wr(8'h44, 32'd0);
    wr(8'h44, 32'd5);
    rdchk("R10 txrdy loaded nonzero", 8'h44, 32'd1);
    wr(8'h44, 32'd0);
  endtask

  task automatic t_storage;
    wr(8'hE4, 32'h0012_3400);
    rdchk("R11 baud store", 8'hE4, 32'h0012_3400);
    wr(8'hD8, 32'h7);
    rdchk("R11 psel2 store", 8'hD8, 32'h7);
    rdchk("R11 unmapped", 8'hF0, 32'h0);
    rdchk("R11 task reads 0", 8'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_enable;
    t_disabled;
    t_mask;
    t_irq;
    t_tasks;
    t_tx;
    t_err;
    t_storage;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule